// File: doc/BRIEF.md
# Path Overhead F2/C2 Byte Source Selector

This block sits on the device side of a serial path-overhead input port. A frame-start pulse marks the first bit of the overhead column. The block counts bit times from that pulse and deserializes the bits that fall in the C2 and F2 byte slots. It keeps the last byte that arrived complete for each of the two slots.

A packed transmit control register holds a separate source select bit for F2 and for C2. For each byte, the select chooses between the serially captured value and a value that software wrote into a byte register. The block also decodes the insertion-type fields and the path AIS enable from the same register. On each per-frame load strobe, it registers the chosen F2 and C2 bytes for the frame builder downstream.

Top module: `poh_byte_source_sel`

## Requirements
- R1: While `rst_n` is low, the control register, both software byte registers, both captured bytes and the `f2_byte`/`c2_byte` outputs clear to zero. After reset, and before the first frame pulse, a load therefore gives zero on both outputs.
- R2: `ser_data` is sampled on the rising clock edge, most significant bit first. Bit time 0 is the edge at which `frame_sync` is high. The C2 byte occupies bit times 16 to 23.
- R3: The F2 byte occupies bit times 48 to 55, counted from the same frame pulse.
- R4: Register writes use `reg_wr` with `reg_addr`. Address 0 is the control register, address 1 is the software F2 value and address 2 is the software C2 value. When control bit 7 is 0, each `byte_load` sets `f2_byte` to the software F2 value.
- R5: When control bit 7 is 1, each `byte_load` sets `f2_byte` to the latest F2 byte received complete on the serial port.
- R6: Control bit 2 selects the C2 source. When it is 0, `byte_load` takes the software C2 value. When it is 1, `byte_load` takes the latest C2 byte received complete on the serial port.
- R7: A serial byte is committed only when its eighth bit arrives. A frame that restarts before then leaves the previously committed byte in place.
- R8: `rei_type` reflects control bits 6:5, `rdi_type` reflects bits 4:3, and `ais_force` reflects bit 0.
- R9: Control bit 1 is unused. It reads back as zero on `ctrl_rd` whatever value is written to it.
- R10: `f2_byte` and `c2_byte` change only on a clock edge where `byte_load` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High during bit time 0 of the overhead column |
| ser_data | input | 1 | Serial overhead data, MSB first |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 F2 value, 2 C2 value |
| reg_wdata | input | 8 | Register write data |
| byte_load | input | 1 | Per-frame strobe that updates the output bytes |
| f2_byte | output | 8 | Selected F2 byte |
| c2_byte | output | 8 | Selected C2 byte |
| ctrl_rd | output | 8 | Control register readback |
| rei_type | output | 2 | REI-P insertion type select |
| rdi_type | output | 2 | RDI-P insertion type select |
| ais_force | output | 1 | Force path AIS |

## Verification
The vector table drives every combination of the two source select bits. In each vector the software and serial values differ, so a swapped or ignored select shows up as the wrong byte. Bits outside the two slots carry a non-constant filler pattern, so a capture window that is shifted by even one bit time yields a different byte. A restarted frame that stops in the middle of the C2 slot separates commit-on-eighth-bit from commit-as-you-go. Changing register values and sending a frame without a load separates output holding from output following.

// File: rtl/poh_byte_source_sel.sv
module poh_byte_source_sel #(
  parameter int C2_POS = 2,
  parameter int F2_POS = 6,
  parameter int CNT_W  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_sync,
  input  logic       ser_data,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       byte_load,
  output logic [7:0] f2_byte,
  output logic [7:0] c2_byte,
  output logic [7:0] ctrl_rd,
  output logic [1:0] rei_type,
  output logic [1:0] rdi_type,
  output logic       ais_force
);
  localparam int SLOT_W = CNT_W - 3;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt, pos;
  logic [7:0] ctrl_q, f2_sw, c2_sw;
  logic [7:0] cap [2];

  assign pos = frame_sync ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt <= CNT_MAX;
    else if (frame_sync)      cnt <= CNT_W'(1);
    else if (cnt != CNT_MAX)  cnt <= cnt + 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam int SLOT = (g == 0) ? C2_POS : F2_POS;
    logic [7:0] sh_q, cap_q;
    logic hit;
    assign hit = pos[CNT_W-1:3] == SLOT_W'(SLOT);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sh_q  <= '0;
        cap_q <= '0;
      end else if (hit) begin
        sh_q <= {sh_q[6:0], ser_data};
        if (pos[2:0] == 3'd7) cap_q <= {sh_q[6:0], ser_data};
      end
    assign cap[g] = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0;
      f2_sw  <= '0;
      c2_sw  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0:    ctrl_q <= reg_wdata & 8'hFD;
        2'd1:    f2_sw  <= reg_wdata;
        2'd2:    c2_sw  <= reg_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f2_byte <= '0;
      c2_byte <= '0;
    end else if (byte_load) begin
      f2_byte <= ctrl_q[7] ? cap[1] : f2_sw;
      c2_byte <= ctrl_q[2] ? cap[0] : c2_sw;
    end

  assign ctrl_rd   = ctrl_q;
  assign rei_type  = ctrl_q[6:5];
  assign rdi_type  = ctrl_q[4:3];
  assign ais_force = ctrl_q[0];
endmodule

// File: rtl/poh_byte_source_sel_chk.sv
module poh_byte_source_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       byte_load,
  input logic [7:0] f2_byte,
  input logic [7:0] c2_byte,
  input logic [7:0] ctrl_rd,
  input logic [1:0] rei_type,
  input logic [1:0] rdi_type,
  input logic       ais_force,
  input logic [7:0] f2_sw,
  input logic [7:0] c2_sw
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_load |=> $stable(f2_byte) && $stable(c2_byte));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[1] == 1'b0);

  p_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd0 |=> ais_force == $past(reg_wdata[0]) &&
      rei_type == $past(reg_wdata[6:5]) && rdi_type == $past(reg_wdata[4:3]));

  p_f2_soft_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load && !ctrl_rd[7] |=> f2_byte == $past(f2_sw));

  p_c2_soft_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load && !ctrl_rd[2] |=> c2_byte == $past(c2_sw));
endmodule

bind poh_byte_source_sel poh_byte_source_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .byte_load(byte_load), .f2_byte(f2_byte),
  .c2_byte(c2_byte), .ctrl_rd(ctrl_rd), .rei_type(rei_type),
  .rdi_type(rdi_type), .ais_force(ais_force), .f2_sw(f2_sw), .c2_sw(c2_sw)
);

// File: tb/poh_byte_source_sel_tb.sv
module poh_byte_source_sel_tb;
  logic clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0, ser_data = 1'b0;
  logic reg_wr = 1'b0, byte_load = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] f2_byte, c2_byte, ctrl_rd;
  logic [1:0] rei_type, rdi_type;
  logic ais_force;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  poh_byte_source_sel u_dut (.*);

  // ctrl, f2 soft, c2 soft, c2 serial, f2 serial
  localparam logic [39:0] VEC [6] = '{
    40'h00_A5_13_C3_3C, 40'h80_11_22_96_E7, 40'h04_5E_77_01_80,
    40'h84_00_FF_6D_B2, 40'h7B_42_99_18_24, 40'hFF_0F_F0_AA_55 };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(logic [7:0] c2, logic [7:0] f2, int nbits);
    for (int p = 0; p < nbits; p++) begin
      frame_sync = (p == 0);
      if (p >= 16 && p < 24)      ser_data = c2[23-p];
      else if (p >= 48 && p < 56) ser_data = f2[55-p];
      else                        ser_data = p[0] ^ p[2];
      @(negedge clk);
    end
    frame_sync = 1'b0; ser_data = 1'b0;
  endtask

  task automatic load();
    byte_load = 1'b1;
    @(negedge clk);
    byte_load = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 f2 reset", f2_byte, 8'h00);
    check("R1 c2 reset", c2_byte, 8'h00);
    check("R1 ctrl reset", ctrl_rd, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    wr(2'd0, 8'h84);
    load();
    check("R1 f2 no frame yet", f2_byte, 8'h00);
    check("R1 c2 no frame yet", c2_byte, 8'h00);

    foreach (VEC[i]) begin
      logic [7:0] c, fs, cs, cser, fser, ce;
      {c, fs, cs, cser, fser} = VEC[i];
      ce = c & 8'hFD;
      wr(2'd0, c); wr(2'd1, fs); wr(2'd2, cs);
      send(cser, fser, 64);
      load();
      check(c[7] ? "R5 R3 f2 serial" : "R4 f2 soft", f2_byte, c[7] ? fser : fs);
      check(c[2] ? "R6 R2 c2 serial" : "R6 c2 soft", c2_byte, c[2] ? cser : cs);
      check("R9 ctrl readback", ctrl_rd, ce);
      check("R8 rei type", {6'd0, rei_type}, {6'd0, c[6:5]});
      check("R8 rdi type", {6'd0, rdi_type}, {6'd0, c[4:3]});
      check("R8 ais", {7'd0, ais_force}, {7'd0, c[0]});
    end

    wr(2'd0, 8'h84);
    send(8'h5A, 8'hC6, 64);
    load();
    check("R2 c2 serial", c2_byte, 8'h5A);
    check("R3 f2 serial", f2_byte, 8'hC6);
    send(8'hFF, 8'h00, 20);
    send(8'h00, 8'h00, 10);
    load();
    check("R7 c2 partial kept old", c2_byte, 8'h5A);
    check("R7 f2 untouched", f2_byte, 8'hC6);

    wr(2'd0, 8'h00); wr(2'd1, 8'h3E); wr(2'd2, 8'hE3);
    send(8'h81, 8'h18, 64);
    check("R10 f2 hold", f2_byte, 8'hC6);
    check("R10 c2 hold", c2_byte, 8'h5A);
    load();
    check("R4 f2 soft after hold", f2_byte, 8'h3E);
    check("R6 c2 soft after hold", c2_byte, 8'hE3);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 f2 mid reset", f2_byte, 8'h00);
    check("R1 ctrl mid reset", ctrl_rd, 8'h00);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule